// File: doc/BRIEF.md
# Step-Select Up/Down Counter with Timed Step Display

This block keeps a 16-bit binary count that is moved by single-cycle pulses coming from an already-debounced button front end. One pulse flips the block between adding and subtracting. Four step pulses each move the count by a fixed amount, in the direction set by the current mode. The step amounts are 1, 5, 10 and 20.

The 16-bit output feeds a separate hex display driver. It normally carries the count. After a step is applied, the output carries the amount that was just applied for a fixed display interval. It then returns to the updated count. A small controller runs a down-counting display timer and selects which value goes to the output.

The interval length in clock cycles is a parameter. It defaults to one second at the clock frequency given by `CLK_FREQ`, and a testbench can shorten it.

Top module: `step_updown_ctr`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the count is 0x0000, the mode is addition and `hex_o` shows 0x0000.
- R2: A pulse on `mode_pulse_i` flips the mode between addition and subtraction. Mode is observed through the direction of later steps.
- R3: A pulse on step_pulse_i bit 0, 1, 2 or 3 changes the count by 1, 5, 10 or 20 (0x0001, 0x0005, 0x000A, 0x0014). The change is an addition in addition mode and a subtraction in subtraction mode. It takes effect at the clock edge that samples the pulse.
- R4: Additions and subtractions wrap modulo 2^16, with no saturation.
- R5: After the edge that accepts a step, `hex_o` shows the applied step value for exactly `DISPLAY_CYCLES` clock cycles.
- R6: When the display interval expires, `hex_o` shows the updated count.
- R7: A step accepted while a step value is being shown is still applied. It replaces the shown value and restarts the full interval.
- R8: When the mode pulse and a step pulse come in the same cycle, the mode flips first and the step uses the new mode.
- R9: When several step pulses come in the same cycle, only the lowest-index one is applied.
- R10: A cycle with no step pulse leaves the count unchanged. A mode pulse alone does not change `hex_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pulse_i | input | 1 | One-cycle pulse that flips between add and subtract |
| step_pulse_i | input | 4 | One-cycle step pulses; bit 0..3 select step 1, 5, 10, 20 |
| hex_o | output | 16 | Value for the hex display: count, or step during the interval |

## Verification
The bench tries every one of the 32 combinations of the mode pulse and the four step pulses. Each combination is applied from both modes, so single steps check the step table and the direction. Combined pulses check that the mode flips before the step and that the lowest-index step wins.

The bench also starts a subtract at 0x0000 and an add near 0xFFFF. These separate modulo wrap from saturation. Step pulses spaced closer than the display interval check the timer restart, as opposed to expiry measured from the first step. Idle runs and lone mode pulses between the steps check the exact interval length and show that the output does not move without a step.

// File: rtl/step_ctr_pkg.sv
package step_ctr_pkg;
  localparam int unsigned N_STEPS = 4;
  localparam int unsigned IDX_W   = $clog2(N_STEPS);
  localparam int unsigned VAL_W   = 16;

  typedef enum logic {
    SHOW_COUNT = 1'b0,
    SHOW_STEP  = 1'b1
  } disp_state_e;

  function automatic logic [VAL_W-1:0] step_amount(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    step_amount = 16'd1;
      2'd1:    step_amount = 16'd5;
      2'd2:    step_amount = 16'd10;
      default: step_amount = 16'd20;
    endcase
  endfunction
endpackage

// File: rtl/step_pick.sv
module step_pick
  import step_ctr_pkg::*;
(
  input  logic [N_STEPS-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [N_STEPS:0]   seen;
  logic [N_STEPS-1:0] grant;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_STEPS; i++) begin : g_pri
    assign grant[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  assign valid_o = seen[N_STEPS];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_STEPS; i++) begin
      if (grant[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/step_datapath.sv
module step_datapath
  import step_ctr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_pulse_i,
  input  logic             en_i,
  input  logic             ldc_i,
  input  logic             sel_out_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] hex_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sub_o
);
  logic [CNT_W-1:0] cnt_q, step_q, step_d;
  logic             sub_q, sub_eff;

  // mode flip is applied ahead of a step in the same cycle
  assign sub_eff = sub_q ^ mode_pulse_i;
  assign step_d  = CNT_W'(step_amount(idx_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= 1'b0;
      cnt_q  <= '0;
      step_q <= '0;
    end else begin
      sub_q <= sub_eff;
      if (en_i) cnt_q <= sub_eff ? cnt_q - step_d : cnt_q + step_d;
      if (ldc_i) step_q <= step_d;
    end
  end

  assign hex_o = sel_out_i ? step_q : cnt_q;
  assign cnt_o = cnt_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/disp_timer.sv
module disp_timer #(
  parameter int unsigned DISPLAY_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic time_out_o
);
  localparam int unsigned TW = (DISPLAY_CYCLES > 1) ? $clog2(DISPLAY_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(DISPLAY_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign time_out_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import step_ctr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_valid_i,
  input  logic time_out_i,
  output logic en_o,
  output logic ldc_o,
  output logic sel_out_o
);
  disp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step_valid_i)    state_d = SHOW_STEP;
    else if (time_out_i) state_d = SHOW_COUNT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SHOW_COUNT;
    else         state_q <= state_d;
  end

  assign en_o      = step_valid_i;
  assign ldc_o     = step_valid_i;
  assign sel_out_o = (state_q == SHOW_STEP);
endmodule

// File: rtl/step_updown_ctr.sv
module step_updown_ctr
  import step_ctr_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned CLK_FREQ       = 100_000_000,
  parameter int unsigned DISPLAY_CYCLES = CLK_FREQ
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_pulse_i,
  input  logic [N_STEPS-1:0] step_pulse_i,
  output logic [CNT_W-1:0]   hex_o
);
  logic             step_valid, en, ldc, sel_out, time_out, sub_mode;
  logic [IDX_W-1:0] step_idx;
  logic [CNT_W-1:0] cnt;

  step_pick u_pick (
    .req_i   (step_pulse_i),
    .valid_o (step_valid),
    .idx_o   (step_idx)
  );

  disp_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_valid_i (step_valid),
    .time_out_i   (time_out),
    .en_o         (en),
    .ldc_o        (ldc),
    .sel_out_o    (sel_out)
  );

  disp_timer #(.DISPLAY_CYCLES(DISPLAY_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ldc),
    .run_i      (sel_out),
    .time_out_o (time_out)
  );

  step_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_pulse_i (mode_pulse_i),
    .en_i         (en),
    .ldc_i        (ldc),
    .sel_out_i    (sel_out),
    .idx_i        (step_idx),
    .hex_o        (hex_o),
    .cnt_o        (cnt),
    .sub_o        (sub_mode)
  );
endmodule

// File: rtl/step_updown_ctr_chk.sv
module step_updown_ctr_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_pulse_i,
  input logic [3:0]       step_pulse_i,
  input logic [CNT_W-1:0] hex_o,
  input logic [CNT_W-1:0] cnt,
  input logic             sub_mode,
  input logic             time_out
);
  logic [CNT_W-1:0] want;
  always_comb begin
    casez (step_pulse_i)
      4'b???1: want = CNT_W'(1);
      4'b??10: want = CNT_W'(5);
      4'b?100: want = CNT_W'(10);
      4'b1000: want = CNT_W'(20);
      default: want = '0;
    endcase
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (hex_o == '0 && !sub_mode));

  // R2
  a_r2_mode_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_pulse_i |=> sub_mode != $past(sub_mode));

  // R3 R4 R8 R9
  a_r3_step_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|step_pulse_i) |=> cnt == ($past(sub_mode ^ mode_pulse_i)
                               ? $past(cnt) - $past(want) : $past(cnt) + $past(want)));

  // R5
  a_r5_step_shown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|step_pulse_i) |=> hex_o == $past(want));

  // R6
  a_r6_return_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_out && !(|step_pulse_i)) |=> (hex_o == cnt && !time_out));

  // R10
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|step_pulse_i) |=> $stable(cnt));
endmodule

bind step_updown_ctr step_updown_ctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_pulse_i (mode_pulse_i),
  .step_pulse_i (step_pulse_i),
  .hex_o        (hex_o),
  .cnt          (cnt),
  .sub_mode     (sub_mode),
  .time_out     (time_out)
);

// File: tb/step_updown_ctr_tb_top.sv
module step_updown_ctr_tb_top;
  localparam int unsigned D = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        mode_pulse_i = 1'b0;
  logic [3:0]  step_pulse_i = '0;
  logic [15:0] hex_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] e_cnt = '0, e_step = '0;
  logic        e_sub = 1'b0;
  int          e_left = 0;

  always #5 clk_i = ~clk_i;

  step_updown_ctr #(.CNT_W(16), .CLK_FREQ(D), .DISPLAY_CYCLES(D)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_pulse_i (mode_pulse_i),
    .step_pulse_i (step_pulse_i),
    .hex_o        (hex_o)
  );

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (hex_o !== exp) begin
      fails++;
      $display("FAIL %s: hex_o=%h expected %h", tag, hex_o, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic tick(input logic m, input logic [3:0] s, input string tag);
    logic [15:0] v;
    mode_pulse_i = m;
    step_pulse_i = s;
    @(posedge clk_i);
    if (m) e_sub = ~e_sub;
    if (s != 0) begin
      v = s[0] ? 16'd1 : s[1] ? 16'd5 : s[2] ? 16'd10 : 16'd20;
      e_cnt  = e_sub ? e_cnt - v : e_cnt + v;
      e_step = v;
      e_left = D;
    end else if (e_left > 0) begin
      e_left--;
    end
    @(negedge clk_i);
    mode_pulse_i = 1'b0;
    step_pulse_i = '0;
    check(tag, (e_left > 0) ? e_step : e_cnt);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 4'b0, tag);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 reset", 16'h0000);
    rst_ni = 1'b1;
    idle(2, "R1 after reset");

    // R4: subtract below zero wraps
    tick(1'b1, 4'b0000, "R2 mode only, R10");
    tick(1'b0, 4'b0001, "R4 wrap down, R3 sub");
    check("R4 wrap value shown as step", 16'h0001);
    idle(D, "R5/R6 interval");
    check("R4 wrapped count", 16'hFFFF);
    tick(1'b1, 4'b0000, "R10 mode only");
    tick(1'b0, 4'b1000, "R4 wrap up, R3 add 20");
    idle(D, "R6 count after wrap");
    check("R4 count 0x0013", 16'h0013);

    // R3: each step alone in each mode
    for (int md = 0; md < 2; md++) begin
      for (int b = 0; b < 4; b++) begin
        tick(1'b0, 4'(1 << b), "R3 single step");
        idle(D - 1, "R5 step held");
        idle(1, "R6 return to count");
      end
      tick(1'b1, 4'b0, "R2 flip, R10 display unchanged");
    end

    // R7: restart during display
    tick(1'b0, 4'b0010, "R7 first step");
    idle(3, "R7 showing");
    tick(1'b0, 4'b0100, "R7 restart");
    idle(D - 1, "R7 restarted interval");
    idle(2, "R7 count back");

    // exhaustive mode x step combos, from both modes
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 32; c++) begin
        tick(c[4], c[3:0], (c[4] && c[3:0] != 0) ? "R8 mode then step" :
                           ($countones(c[3:0]) > 1) ? "R9 lowest wins" : "R3 combo");
        idle((c % 3 == 0) ? D : 2, "R5 R6 R7 combo follow");
      end
      tick(1'b1, 4'b0, "R2 flip");
      idle(D, "R10 idle");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule